// File: doc/BRIEF.md
# I2C Status Flag Register

This block holds the eight event flags of an I2C controller in one byte. Each flag is set by a one-cycle strobe from the bus engine, the shift path or the mode logic. Software clears a flag in two steps. It must first read the register while that flag is 1, and then write 0 to that bit. Accesses to the transmit and receive holding registers also clear some flags as a side effect. One bit changes meaning with the transfer format: in I2C format it reports lost arbitration, and in clocked-synchronous format it reports receive overrun.

The register read data is the flag vector itself. A read strobe arms the bits that read back as 1. A write strobe then clears each armed bit whose written value is 0.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset all flags are 0. `reg_rdata` always equals `flags`.
- R2: A written 0 clears a flag only if a read strobe saw that flag at 1 before the write. A 0 written without that read, or a written 1, leaves the flag unchanged.
- R3: Any register write disarms every bit. A further write of 0 with no new read between does not clear anything.
- R4: When a set event and a clear of the same flag fall in the same cycle, the flag ends at 1.
- R5: Bit 0 (general call) and bit 1 (own-address match) set only in slave receive with I2C format (`is_master`=0, `is_tx`=0, `sync_mode`=0).
- R6: In I2C format, bit 2 sets in two cases. The first is an SDA mismatch strobe in master transmit. The second is a start detected while `sda_in`=1 in master mode.
- R7: In synchronous format (`sync_mode`=1), bit 2 sets when the last receive bit arrives while bit 5 is 1. Otherwise that event has no effect.
- R8: Bit 3 sets on a stop condition only if a 9th SCL rise occurred since the last start or stop.
- R9: Bit 4 sets on a high acknowledge only when `ack_chk_en`=1 and the format is I2C.
- R10: Bit 5 sets when a byte is loaded into the receive holding register. It clears on a read of that register.
- R11: In I2C format, bit 6 sets at the 9th SCL rise only while bit 7 is 1. In synchronous format it sets when the last transmit bit is shifted out.
- R12: Bit 7 sets on any of these events: a holding-to-shift load, a start generation, or a 0-to-1 change of `is_tx` (this covers the switch from slave receive to slave transmit).
- R13: A write to the transmit holding register clears bits 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = master mode |
| is_tx | input | 1 | 1 = transmit mode |
| sync_mode | input | 1 | 1 = clocked-synchronous format, 0 = I2C format |
| ack_chk_en | input | 1 | Enables the no-acknowledge check |
| sda_in | input | 1 | Sampled SDA pin level |
| ev_gcall | input | 1 | General call address received |
| ev_addr_match | input | 1 | First frame after start matched own 7-bit address |
| ev_sda_mismatch | input | 1 | Driven SDA differed from pin at SCL rise |
| bus_start | input | 1 | Start condition detected on the bus |
| bus_stop | input | 1 | Stop condition detected on the bus |
| ev_scl9_rise | input | 1 | Rising edge of the 9th SCL clock |
| ev_ack_high | input | 1 | Acknowledge bit sampled high after a sent byte |
| ev_rx_load | input | 1 | Shift register copied into receive holding register |
| ev_rx_last_bit | input | 1 | Last bit of a receive word arrived |
| ev_tx_load | input | 1 | Transmit holding register moved into shift register |
| ev_tx_last_bit | input | 1 | Last bit of a synchronous frame shifted out |
| ev_start_gen | input | 1 | Start or repeated start generated |
| dr_tx_wr | input | 1 | Write to transmit holding register |
| dr_rx_rd | input | 1 | Read of receive holding register |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read data |
| flags | output | 8 | Flag vector |

## Verification
The bench builds the block with its single parameter at the default value, `SET_OVER_CLR`=1. That value gives set events priority over every clear, so R4 can be checked. This is done by pairing a receive load with an armed software clear, and by pairing a start generation with a transmit holding write. The bench also runs both transfer formats and several master, slave, transmit and receive settings. These cover the gating of every flag and both meanings of bit 2.

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg #(
  parameter bit SET_OVER_CLR = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_master,
  input  logic       is_tx,
  input  logic       sync_mode,
  input  logic       ack_chk_en,
  input  logic       sda_in,
  input  logic       ev_gcall,
  input  logic       ev_addr_match,
  input  logic       ev_sda_mismatch,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       ev_scl9_rise,
  input  logic       ev_ack_high,
  input  logic       ev_rx_load,
  input  logic       ev_rx_last_bit,
  input  logic       ev_tx_load,
  input  logic       ev_tx_last_bit,
  input  logic       ev_start_gen,
  input  logic       dr_tx_wr,
  input  logic       dr_rx_rd,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [7:0] flags
);

  localparam int B_RDRF = 5;
  localparam int B_TEND = 6;
  localparam int B_TDRE = 7;

  logic [7:0] flg, armed, set_v, clr_v, nxt;
  logic       tx_q, frame_q;

  wire i2c    = !sync_mode;
  wire slv_rx = !is_master && !is_tx && i2c;

  assign set_v[0] = ev_gcall & slv_rx;
  assign set_v[1] = ev_addr_match & slv_rx;
  assign set_v[2] = i2c ? ((ev_sda_mismatch & is_master & is_tx) | (bus_start & sda_in & is_master))
                        : (ev_rx_last_bit & flg[B_RDRF]);
  assign set_v[3] = bus_stop & frame_q & i2c;
  assign set_v[4] = ev_ack_high & ack_chk_en & i2c;
  assign set_v[5] = ev_rx_load;
  assign set_v[6] = i2c ? (ev_scl9_rise & flg[B_TDRE]) : ev_tx_last_bit;
  assign set_v[7] = ev_tx_load | (is_tx & ~tx_q) | ev_start_gen;

  assign clr_v = ({8{reg_wr}} & ~reg_wdata & armed)
               | {dr_tx_wr, dr_tx_wr, dr_rx_rd, 5'b0};

  assign nxt = SET_OVER_CLR ? ((flg & ~clr_v) | set_v) : ((flg | set_v) & ~clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg     <= '0;
      armed   <= '0;
      tx_q    <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      flg  <= nxt;
      tx_q <= is_tx;
      if (reg_wr)      armed <= '0;
      else if (reg_rd) armed <= armed | flg;
      if (bus_start || bus_stop) frame_q <= 1'b0;
      else if (ev_scl9_rise)     frame_q <= 1'b1;
    end
  end

  assign flags     = flg;
  assign reg_rdata = flg;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> flags == 8'h00);

  a_r2_fall_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(reg_wr || dr_tx_wr || dr_rx_rd));

  a_r4_rx_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_load |=> flags[B_RDRF]);

  a_r10_rx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rx_rd && !ev_rx_load) |=> !flags[B_RDRF]);

  a_r13_tx_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_tx_wr && !set_v[B_TDRE] && !set_v[B_TEND]) |=> (!flags[B_TDRE] && !flags[B_TEND]));

  a_r9_nack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_chk_en && !flags[4]) |=> !flags[4]);

endmodule

// File: tb/test_i2c_stat_reg.sv
module test_i2c_stat_reg;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 0, is_tx = 0, sync_mode = 0, ack_chk_en = 0, sda_in = 0;
  logic ev_gcall, ev_addr_match, ev_sda_mismatch, bus_start, bus_stop, ev_scl9_rise;
  logic ev_ack_high, ev_rx_load, ev_rx_last_bit, ev_tx_load, ev_tx_last_bit, ev_start_gen;
  logic dr_tx_wr, dr_rx_rd, reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata, flags;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_reg i_i2c_stat_reg (
    .clk, .rst_n, .is_master, .is_tx, .sync_mode, .ack_chk_en, .sda_in,
    .ev_gcall, .ev_addr_match, .ev_sda_mismatch, .bus_start, .bus_stop,
    .ev_scl9_rise, .ev_ack_high, .ev_rx_load, .ev_rx_last_bit, .ev_tx_load,
    .ev_tx_last_bit, .ev_start_gen, .dr_tx_wr, .dr_rx_rd, .reg_rd, .reg_wr,
    .reg_wdata, .reg_rdata, .flags
  );

  task automatic nxt();
    @(negedge clk);
    {ev_gcall, ev_addr_match, ev_sda_mismatch, bus_start, bus_stop, ev_scl9_rise} = '0;
    {ev_ack_high, ev_rx_load, ev_rx_last_bit, ev_tx_load, ev_tx_last_bit, ev_start_gen} = '0;
    {dr_tx_wr, dr_rx_rd, reg_rd, reg_wr} = '0;
    reg_wdata = 8'h00;
  endtask

  task automatic expect_v(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(flags, e.v, e.tag);
      chk(reg_rdata, flags, "R1 rdata mirror");
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    nxt();
    nxt();
    chk(flags, 8'h00, "R1 in reset");
    rst_n = 1'b1;
    nxt(); expect_v(8'h00, "R1 after reset");
    // R5 general call / address match gating
    nxt(); ev_gcall = 1; expect_v(8'h01, "R5 gcall slave rx");
    nxt(); is_master = 1; ev_addr_match = 1; expect_v(8'h01, "R5 addr ignored in master");
    nxt(); is_master = 0; ev_addr_match = 1; expect_v(8'h03, "R5 addr match");
    // R2/R3 software clear
    nxt(); reg_wr = 1; reg_wdata = 8'h00; expect_v(8'h03, "R2 write0 unarmed");
    nxt(); reg_rd = 1; expect_v(8'h03, "R2 read arms");
    nxt(); reg_wr = 1; reg_wdata = 8'hFE; expect_v(8'h02, "R2 armed clear bit0");
    nxt(); reg_wr = 1; reg_wdata = 8'hFD; expect_v(8'h02, "R3 disarmed by write");
    nxt(); reg_wr = 1; reg_wdata = 8'hFF; expect_v(8'h02, "R2 write1 no effect");
    nxt(); reg_rd = 1; expect_v(8'h02, "R2 read");
    nxt(); reg_wr = 1; expect_v(8'h00, "R2 clear bit1");
    // R10/R4
    nxt(); ev_rx_load = 1; expect_v(8'h20, "R10 rx load");
    nxt(); reg_rd = 1; expect_v(8'h20, "R2 read");
    nxt(); reg_wr = 1; ev_rx_load = 1; expect_v(8'h20, "R4 set beats sw clear");
    nxt(); dr_rx_rd = 1; expect_v(8'h00, "R10 rx read clears");
    // R7 overrun in sync format
    nxt(); sync_mode = 1; ev_rx_last_bit = 1; expect_v(8'h00, "R7 no overrun when empty");
    nxt(); ev_rx_load = 1; expect_v(8'h20, "R10 rx load sync");
    nxt(); ev_rx_last_bit = 1; expect_v(8'h24, "R7 overrun");
    nxt(); dr_rx_rd = 1; expect_v(8'h04, "R10 rx read");
    nxt(); reg_rd = 1; expect_v(8'h04, "R2 read");
    nxt(); reg_wr = 1; expect_v(8'h00, "R2 clear bit2");
    // R11 sync transmit end, R13
    nxt(); ev_tx_last_bit = 1; expect_v(8'h40, "R11 sync last bit");
    nxt(); dr_tx_wr = 1; expect_v(8'h00, "R13 tx write clears");
    // R6 arbitration lost
    nxt(); sync_mode = 0; is_master = 1; is_tx = 1; expect_v(8'h80, "R12 tx mode select");
    nxt(); ev_sda_mismatch = 1; expect_v(8'h84, "R6 sda mismatch");
    nxt(); dr_tx_wr = 1; expect_v(8'h04, "R13 tx write clears");
    nxt(); reg_rd = 1; expect_v(8'h04, "R2 read");
    nxt(); reg_wr = 1; expect_v(8'h00, "R2 clear bit2");
    nxt(); is_tx = 0; bus_start = 1; sda_in = 1; expect_v(8'h04, "R6 start with sda high");
    nxt(); sda_in = 0; reg_rd = 1; expect_v(8'h04, "R2 read");
    nxt(); reg_wr = 1; expect_v(8'h00, "R2 clear bit2");
    // R8 stop after frame
    nxt(); bus_stop = 1; expect_v(8'h00, "R8 stop without frame");
    nxt(); ev_scl9_rise = 1; expect_v(8'h00, "R11 no tend when tdre 0");
    nxt(); bus_stop = 1; expect_v(8'h08, "R8 stop after frame");
    nxt(); reg_rd = 1; expect_v(8'h08, "R2 read");
    nxt(); reg_wr = 1; expect_v(8'h00, "R2 clear bit3");
    nxt(); bus_stop = 1; expect_v(8'h00, "R8 frame consumed");
    // R12 / R11 / R13 / R4
    nxt(); ev_start_gen = 1; expect_v(8'h80, "R12 start gen");
    nxt(); ev_scl9_rise = 1; expect_v(8'hC0, "R11 tend on 9th rise");
    nxt(); dr_tx_wr = 1; expect_v(8'h00, "R13 tx write clears both");
    nxt(); ev_tx_load = 1; expect_v(8'h80, "R12 tx load");
    nxt(); dr_tx_wr = 1; ev_start_gen = 1; expect_v(8'h80, "R4 set beats tx write");
    nxt(); dr_tx_wr = 1; expect_v(8'h00, "R13 tx write");
    // R9 no-acknowledge
    nxt(); ev_ack_high = 1; expect_v(8'h00, "R9 ack check off");
    nxt(); ack_chk_en = 1; ev_ack_high = 1; expect_v(8'h10, "R9 nack");
    nxt(); reg_rd = 1; expect_v(8'h10, "R2 read");
    nxt(); reg_wr = 1; expect_v(8'h00, "R2 clear bit4");
    // R12 slave rx -> slave tx, R5 gating in transmit
    nxt(); is_master = 0; expect_v(8'h00, "R12 idle slave rx");
    nxt(); is_tx = 1; expect_v(8'h80, "R12 slave rx to tx");
    nxt(); ev_gcall = 1; expect_v(8'h80, "R5 gcall ignored in tx");
    nxt();
    nxt();
    nxt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule